// File: doc/BRIEF.md
# Seven-Level Space Vector Switching Sequencer

This block turns three phase references into gate enables for a three-phase inverter whose phase legs each produce seven voltage levels, from three source steps below zero to three above. Once per switching period it takes one sample of the three references. These are signed fixed-point numbers already expressed in units of one DC source step. It then plans the switching sequence for the next period and plays that sequence out against a free-running period counter. No sector tables and no trigonometry are involved.

Planning works as follows. Each reference is split into a floor integer part and a non-negative fraction. The three fractions are ranked from largest to smallest. A triangular set of unit step patterns, reordered by that ranking, is added to the integer parts to give four phase-level vectors. Each vector's dwell is derived only from the sorted fractions. The sequence starts at the integer levels, and phases step up by one level in rank order. Each step happens at a cycle offset fixed by that phase's fraction. A per-phase decoder maps each level onto the five switch enables of that leg.

Top module: `svm7_seq`

## Requirements
- R1: `period_sync` is high for exactly one clock cycle at the start of every switching period. Periods are `PERIOD_CYC = CLK_HZ / SW_HZ` cycles long, and the first cycle after reset is a period start.
- R2: References are sampled only on the clock edge that ends a period. Reference values at any other time have no effect on the outputs. The plan sampled at one boundary drives the whole following period.
- R3: Each reference is two's complement with `FRAC_W` fraction bits, in source-step units. Its integer part is the floor of the value and its fraction is the low `FRAC_W` bits. Every phase begins each period at its integer level.
- R4: Within a period, phases step up by exactly one level in descending order of fraction, and equal fractions are ordered A, then B, then C. Consecutive vectors of the plan differ in the level of at most one phase.
- R5: A phase with fraction f (an integer count of 2^-FRAC_W) steps up at offset floor(PERIOD_CYC·(2^FRAC_W − f) / 2^FRAC_W) cycles after the period start. A zero fraction never steps. Equal fractions step in the same cycle, so the vector between them lasts zero cycles.
- R6: Gate bit n−1 enables switch n. The gate codes are +3 = 5'b10001, +2 = 5'b10010, +1 = 5'b10100, 0 = 5'b00000, −1 = 5'b01001, −2 = 5'b01010, −3 = 5'b01100.
- R7: Phase levels are clamped to the range −3 to +3 before decoding.
- R8: `ovm_flag` is set from the cycle after a boundary whose sampled reference on any phase is above +3.0 or below −3.0. It then stays set until reset. A reference of exactly ±3.0 does not set it.
- R9: While reset is held (synchronous, active low), all gate outputs are zero, `ovm_flag` is low and `period_sync` is high. The first period after reset keeps all gates off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_a | input | REF_W | Phase A reference, signed, FRAC_W fraction bits |
| ref_b | input | REF_W | Phase B reference |
| ref_c | input | REF_W | Phase C reference |
| gate_a | output | 5 | Phase A switch enables, bit n−1 = switch n |
| gate_b | output | 5 | Phase B switch enables |
| gate_c | output | 5 | Phase C switch enables |
| period_sync | output | 1 | High in the first cycle of each switching period |
| ovm_flag | output | 1 | Sticky overmodulation indication |

## Verification
The assertions assume that `PERIOD_CYC` is at least two. They also assume that references never stray so far that the integer part overflows its `REF_W − FRAC_W` bits. The clamp and the vector step property rely on the floor integer plus one still being representable. The stimulus keeps every reference, including deliberate junk values held mid-period, within ±7.5 source steps, which fits a 4-bit integer part. It also places every change away from the sampling edge, using the bench's own period count.

// File: rtl/svm_pkg.sv
// Shared types and the level-to-gate code for the seven-level sequencer.
// Assumes three phases and a level range of -3..+3 held in 3-bit signed.
package svm_pkg;
    localparam int NPH     = 3;
    localparam int NVEC    = NPH + 1;
    localparam int IDX_W   = 2;
    localparam int GATE_W  = 5;
    localparam int LVL_MAX = 3;

    typedef logic signed [2:0] lvl_t;

    // Map a phase level onto the five switch enables of one leg.
    function automatic logic [GATE_W-1:0] lvl_to_gates(lvl_t l);
        case (l)
            3'b011:  return 5'b10001;
            3'b010:  return 5'b10010;
            3'b001:  return 5'b10100;
            3'b111:  return 5'b01001;
            3'b110:  return 5'b01010;
            3'b101:  return 5'b01100;
            default: return 5'b00000;
        endcase
    endfunction
endpackage

// File: rtl/svm_rank.sv
// Ranks the phase fractions, 0 = largest. Equal fractions rank by phase
// index, lowest first, so the result is a strict permutation.
module svm_rank import svm_pkg::*; #(
    parameter int FW = 8
) (
    input  logic [NPH-1:0][FW-1:0]    frac_i,
    output logic [NPH-1:0][IDX_W-1:0] rank_o
);
    for (genvar i = 0; i < NPH; i++) begin : g_ph
        logic [IDX_W-1:0] r;
        // Count the phases that must step before phase i.
        always_comb begin
            r = '0;
            for (int j = 0; j < NPH; j++) begin
                if (j != i && (frac_i[j] > frac_i[i] ||
                               (frac_i[j] == frac_i[i] && j < i)))
                    r = r + 1'b1;
            end
        end
        assign rank_o[i] = r;
    end
endmodule

// File: rtl/svm_dwell.sv
// Turns the ranked fractions into the cycle offsets where vectors 1..3
// begin. Offset k = floor(T*(1 - f_k)) with f_k the k-th largest fraction;
// the dwells t0..t3 are the gaps between these offsets and T.
module svm_dwell import svm_pkg::*; #(
    parameter int FW         = 8,
    parameter int PERIOD_CYC = 40,
    parameter int BW         = 6
) (
    input  logic [NPH-1:0][FW-1:0]    frac_i,
    input  logic [NPH-1:0][IDX_W-1:0] rank_i,
    output logic [NPH-1:0][BW-1:0]    bnd_o
);
    localparam int PW = BW + FW;

    for (genvar k = 0; k < NPH; k++) begin : g_bnd
        logic [FW-1:0] fs;
        logic [PW-1:0] prod;
        // Pick the fraction that holds rank k.
        always_comb begin
            fs = '0;
            for (int p = 0; p < NPH; p++)
                if (rank_i[p] == IDX_W'(k)) fs = frac_i[p];
        end
        assign prod     = PW'(PERIOD_CYC) * (PW'(2 ** FW) - PW'(fs));
        assign bnd_o[k] = prod[PW-1:FW];
    end
endmodule

// File: rtl/svm_gate_dec.sv
// Per-phase decode of the current level into the leg's switch enables.
module svm_gate_dec import svm_pkg::*; (
    input  lvl_t [NPH-1:0]             lvl_i,
    output logic [NPH-1:0][GATE_W-1:0] gate_o
);
    for (genvar p = 0; p < NPH; p++) begin : g_dec
        assign gate_o[p] = lvl_to_gates(lvl_i[p]);
    end
endmodule

// File: rtl/svm7_seq.sv
// Seven-level space vector sequencer. It samples three references at each
// period boundary, plans four vectors plus their start offsets, and plays
// them out against the period counter. Assumes PERIOD_CYC >= 2 and that
// references fit the REF_W-FRAC_W integer field.
module svm7_seq import svm_pkg::*; #(
    parameter int REF_W  = 12,
    parameter int FRAC_W = 8,
    parameter int CLK_HZ = 100_000_000,
    parameter int SW_HZ  = 2000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [REF_W-1:0] ref_a,
    input  logic signed [REF_W-1:0] ref_b,
    input  logic signed [REF_W-1:0] ref_c,
    output logic [GATE_W-1:0]       gate_a,
    output logic [GATE_W-1:0]       gate_b,
    output logic [GATE_W-1:0]       gate_c,
    output logic                    period_sync,
    output logic                    ovm_flag
);
    localparam int PERIOD_CYC = CLK_HZ / SW_HZ;
    localparam int CW = $clog2(PERIOD_CYC);
    localparam int BW = $clog2(PERIOD_CYC + 1);
    localparam int IW = REF_W - FRAC_W;
    localparam logic signed [IW:0] HI = (IW+1)'(LVL_MAX);
    localparam logic signed [IW:0] LO = -(IW+1)'(LVL_MAX);
    localparam logic signed [REF_W-1:0] LIM_HI = REF_W'(LVL_MAX * (2 ** FRAC_W));
    localparam logic signed [REF_W-1:0] LIM_LO = -LIM_HI;

    logic signed [REF_W-1:0] ref_v [NPH];
    logic signed [IW-1:0]    int_v [NPH];
    logic [NPH-1:0][FRAC_W-1:0] frac_v;
    logic [NPH-1:0][IDX_W-1:0]  rank_v;
    logic [NPH-1:0][BW-1:0]     bnd_d, bnd_q;
    lvl_t [NVEC-1:0][NPH-1:0]   vec_d, vec_q;
    lvl_t [NPH-1:0]             cur_lvl;
    logic [NPH-1:0][GATE_W-1:0] gate_v;
    logic [NPH-1:0]             ovm_ph;
    logic [CW-1:0]              cnt;
    logic [IDX_W-1:0]           idx;
    logic                       last;

    assign ref_v[0] = ref_a;
    assign ref_v[1] = ref_b;
    assign ref_v[2] = ref_c;

    for (genvar p = 0; p < NPH; p++) begin : g_split
        assign int_v[p]  = ref_v[p][REF_W-1:FRAC_W];
        assign frac_v[p] = ref_v[p][FRAC_W-1:0];
        assign ovm_ph[p] = (ref_v[p] > LIM_HI) || (ref_v[p] < LIM_LO);
    end

    svm_rank #(.FW(FRAC_W)) u_rank (
        .frac_i (frac_v),
        .rank_o (rank_v)
    );

    svm_dwell #(.FW(FRAC_W), .PERIOD_CYC(PERIOD_CYC), .BW(BW)) u_dwell (
        .frac_i (frac_v),
        .rank_i (rank_v),
        .bnd_o  (bnd_d)
    );

    // Vector k: integer part plus one on every phase ranked below k, clamped.
    for (genvar k = 0; k < NVEC; k++) begin : g_vec
        for (genvar p = 0; p < NPH; p++) begin : g_ph
            logic signed [IW:0] raw;
            assign raw = $signed({int_v[p][IW-1], int_v[p]}) +
                         $signed({{IW{1'b0}}, (rank_v[p] < IDX_W'(k))});
            assign vec_d[k][p] = (raw > HI) ? lvl_t'(LVL_MAX) :
                                 (raw < LO) ? lvl_t'(-LVL_MAX) : raw[2:0];
        end
    end

    assign last = (cnt == CW'(PERIOD_CYC - 1));

    // Free-running period counter.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (last) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end

    // Latch the next period's plan at the boundary only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q <= '0;
            for (int k = 0; k < NPH; k++) bnd_q[k] <= BW'(PERIOD_CYC);
        end else if (last) begin
            vec_q <= vec_d;
            bnd_q <= bnd_d;
        end
    end

    // Sticky overmodulation flag from the sampled references.
    always_ff @(posedge clk) begin
        if (!rst_n)                 ovm_flag <= 1'b0;
        else if (last && |ovm_ph)   ovm_flag <= 1'b1;
    end

    // Active vector index: number of start offsets already reached.
    always_comb begin
        idx = '0;
        for (int k = 0; k < NPH; k++)
            if (BW'(cnt) >= bnd_q[k]) idx = idx + 1'b1;
    end

    for (genvar p = 0; p < NPH; p++) begin : g_cur
        assign cur_lvl[p] = vec_q[idx][p];
    end

    svm_gate_dec u_dec (
        .lvl_i  (cur_lvl),
        .gate_o (gate_v)
    );

    assign gate_a      = gate_v[0];
    assign gate_b      = gate_v[1];
    assign gate_c      = gate_v[2];
    assign period_sync = (cnt == '0);
endmodule

// File: rtl/svm7_seq_chk.sv
// Property checker for svm7_seq, bound into every instance below.
// Assumes PERIOD_CYC >= 2.
module svm7_seq_chk import svm_pkg::*; #(
    parameter int PERIOD_CYC = 40,
    parameter int CW = 6,
    parameter int BW = 6
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [CW-1:0]            cnt,
    input lvl_t [NVEC-1:0][NPH-1:0] vec_q,
    input logic [NPH-1:0][BW-1:0]   bnd_q,
    input logic [GATE_W-1:0]        gate_a,
    input logic [GATE_W-1:0]        gate_b,
    input logic [GATE_W-1:0]        gate_c,
    input logic                     period_sync,
    input logic                     ovm_flag
);
    logic [CW-1:0] gap;

    // Cycles elapsed since the last period_sync.
    always_ff @(posedge clk) begin
        if (!rst_n)           gap <= '0;
        else if (period_sync) gap <= CW'(1);
        else                  gap <= gap + 1'b1;
    end

    p_sync_spacing_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (gap == CW'(PERIOD_CYC - 1)) |=> period_sync);
    p_sync_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        period_sync |=> !period_sync);

    p_plan_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0) |-> ($stable(vec_q) && $stable(bnd_q)));

    p_bnd_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bnd_q[0] <= bnd_q[1]) && (bnd_q[1] <= bnd_q[2]) &&
        (bnd_q[2] <= BW'(PERIOD_CYC)));

    for (genvar k = 0; k < NPH; k++) begin : g_step
        logic [NPH-1:0] diff;
        for (genvar p = 0; p < NPH; p++) begin : g_d
            assign diff[p] = (vec_q[k][p] != vec_q[k+1][p]);
        end
        p_single_phase_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(diff) <= 1);
    end

    for (genvar k = 0; k < NVEC; k++) begin : g_rng
        for (genvar p = 0; p < NPH; p++) begin : g_p
            p_level_clamp_r7: assert property (@(posedge clk) disable iff (!rst_n)
                vec_q[k][p] != 3'b100);
        end
    end

    p_gate_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_a == '0 || ($countones(gate_a[4:3]) == 1 && $countones(gate_a[2:0]) == 1)) &&
        (gate_b == '0 || ($countones(gate_b[4:3]) == 1 && $countones(gate_b[2:0]) == 1)) &&
        (gate_c == '0 || ($countones(gate_c[4:3]) == 1 && $countones(gate_c[2:0]) == 1)));

    p_ovm_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ovm_flag |=> ovm_flag);
endmodule

bind svm7_seq svm7_seq_chk #(.PERIOD_CYC(PERIOD_CYC), .CW(CW), .BW(BW)) u_svm7_seq_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnt         (cnt),
    .vec_q       (vec_q),
    .bnd_q       (bnd_q),
    .gate_a      (gate_a),
    .gate_b      (gate_b),
    .gate_c      (gate_c),
    .period_sync (period_sync),
    .ovm_flag    (ovm_flag)
);

// File: tb/svm7_seq_bench.sv
// Bench: behavioural per-phase threshold model, compared every cycle.
module svm7_seq_bench;
    localparam int CLK_PER = 10;
    localparam int REF_W   = 12;
    localparam int FW      = 8;
    localparam int CLK_HZ  = 80_000;
    localparam int SW_HZ   = 2000;
    localparam int T       = CLK_HZ / SW_HZ;
    localparam int ONE     = 1 << FW;
    localparam int NPAT    = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic signed [REF_W-1:0] ra = '0, rb = '0, rc = '0;
    logic [4:0] gate_a, gate_b, gate_c;
    logic period_sync, ovm_flag;

    always #(CLK_PER/2) clk = ~clk;

    svm7_seq #(.REF_W(REF_W), .FRAC_W(FW), .CLK_HZ(CLK_HZ), .SW_HZ(SW_HZ)) u_svm7_seq (
        .clk(clk), .rst_n(rst_n), .ref_a(ra), .ref_b(rb), .ref_c(rc),
        .gate_a(gate_a), .gate_b(gate_b), .gate_c(gate_c),
        .period_sync(period_sync), .ovm_flag(ovm_flag)
    );

    int checks = 0, fails = 0;
    int mcnt = 0;
    int mint [3] = '{0, 0, 0};
    int mthr [3] = '{T, T, T};
    bit mflag = 0, started = 0, junk = 0, done = 0;

    int pa [NPAT] = '{128,  384,  512, -448,  896, -896,  -64};
    int pb [NPAT] = '{ 64,  384, -768,  742, -640,  768,  300};
    int pc [NPAT] = '{192, -128,    0,   26,  256, -256, -700};

    function automatic int clampl(int v);
        return (v > 3) ? 3 : (v < -3) ? -3 : v;
    endfunction

    function automatic int enc(int l);
        case (l)
            3: return 5'b10001;  2: return 5'b10010;  1: return 5'b10100;
            -1: return 5'b01001; -2: return 5'b01010; -3: return 5'b01100;
            default: return 0;
        endcase
    endfunction

    task automatic chk(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d mcnt=%0d", tag, got, exp, mcnt);
        end
    endtask

    // Reference model: each phase steps when the period count reaches its threshold.
    always @(posedge clk) begin
        if (!rst_n) begin
            mcnt = 0; mflag = 0;
            for (int p = 0; p < 3; p++) begin mint[p] = 0; mthr[p] = T; end
        end else if (mcnt == T - 1) begin
            int r [3];
            r[0] = int'(ra); r[1] = int'(rb); r[2] = int'(rc);
            for (int p = 0; p < 3; p++) begin
                int fr;
                mint[p] = r[p] >>> FW;
                fr      = r[p] - mint[p] * ONE;
                mthr[p] = (T * (ONE - fr)) / ONE;
                if (r[p] > 3 * ONE || r[p] < -3 * ONE) mflag = 1;
            end
            mcnt = 0;
        end else begin
            mcnt = mcnt + 1;
        end
    end

    // Compare every cycle away from the active edge.
    always @(negedge clk) begin
        if (started && !done) begin
            int g [3];
            g[0] = int'(gate_a); g[1] = int'(gate_b); g[2] = int'(gate_c);
            for (int p = 0; p < 3; p++) begin
                int e;
                e = clampl(mint[p] + ((mcnt >= mthr[p]) ? 1 : 0));
                if (junk) chk("R2 gates under junk input", g[p], enc(e));
                else      chk("R3 R4 R5 R6 R7 gates", g[p], enc(e));
            end
            chk("R1 period_sync", int'(period_sync), (mcnt == 0) ? 1 : 0);
            chk("R8 ovm_flag", int'(ovm_flag), int'(mflag));
        end
    end

    task automatic wait_cnt(int v);
        do @(negedge clk); while (mcnt != v);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R9 reset gate_a", int'(gate_a), 0);
        chk("R9 reset gate_b", int'(gate_b), 0);
        chk("R9 reset gate_c", int'(gate_c), 0);
        chk("R9 reset ovm_flag", int'(ovm_flag), 0);
        chk("R9 reset period_sync", int'(period_sync), 1);
        rst_n   = 1'b1;
        started = 1'b1;
        for (int i = 0; i < NPAT; i++) begin
            wait_cnt(10);
            junk = 1;
            ra = 12'sd1900; rb = -12'sd1900; rc = 12'sd1000;
            wait_cnt(20);
            junk = 0;
            ra = REF_W'(pa[i]); rb = REF_W'(pb[i]); rc = REF_W'(pc[i]);
        end
        repeat (2 * T) @(negedge clk);
        chk("R8 flag held at end", int'(ovm_flag), 1);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog R1 actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule